// File: doc/BRIEF.md
# Chess Attacker and Victim Selector

This block answers two questions about a chess position held elsewhere. Given a target square, it reports the cheapest enabled friendly piece that attacks that square. Without a target, it reports the most valuable enabled enemy piece on the board. A move generator can pair the two queries to list captures from the most valuable victim down to the cheapest attacker. The board arrives as a flat vector of 4-bit square codes, together with a 64-bit enable mask. The mask lets the controlling processor remove squares that have already been tried.

Attack detection runs as a network. For each of the eight ray directions, a lane starts a single-bit front next to the target and moves it one square per cycle. The front stops at the first occupied square and records that square if it holds a friendly slider of the right kind. Knight, king and pawn attacks are resolved combinationally from the rank and file differences. A receiver per square turns the query type, the piece code, the enable bit and the attack bit into a 3-bit priority. A binary arbitration tree then selects the winner. The result byte carries the square index, an end-of-list flag and an illegal-position flag, and a one-cycle `done_o` pulse marks it. The board and the mask must stay stable from the command until `done_o`.

Piece codes use bit 3 for colour (0 = friendly, 1 = enemy) and bits 2:0 for the kind: 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king. Kinds 0 and 7 mean empty. Square index = rank*8 + file.

Top module: `atk_query_engine`

## Requirements
- R1: After reset, `result_o` is 8'h00 and `done_o` is low.
- R2: The attacker query is opcode 4'b1111 in `cmd_i[15:12]`, with the target square in `cmd_i[9:4]`. It returns the enabled friendly attacker of lowest value, with the order pawn < knight < bishop < rook < queen < king. Enemy pieces never count as attackers.
- R3: A rook, bishop or queen attacks along its lines up to the board edge, up to 7 squares away. The first occupied square of either colour blocks the line beyond it.
- R4: Knight and king attacks follow their usual geometry. A square index difference that wraps across a board edge is not an attack.
- R5: A friendly pawn attacks only the two squares one rank higher and one file to either side, never across the a/h edge.
- R6: The victim query is opcode 4'b1110. It returns the enabled enemy piece of highest value.
- R7: A square whose enable bit is clear never wins either query.
- R8: When several candidates share the best value, the lowest square index wins.
- R9: When no candidate exists, `result_o[6]` (end flag) is 1 and `result_o[5:0]` is 0. Otherwise `result_o[6]` is 0 and `result_o[5:0]` is the winner.
- R10: `result_o[7]` (illegal flag) is 1 only for an attacker query whose target holds an enemy king that at least one friendly piece attacks, enabled or not. It is always 0 for a victim query.
- R11: `done_o` is a one-cycle pulse. It rises 8 clock edges after an attacker query is accepted and 1 edge after a victim query is accepted. `result_o` holds its value until the next pulse.
- R12: Other opcodes, and any command presented while a query is in progress, are ignored: no `done_o` pulse follows and `result_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command strobe, sampled at a clock edge |
| cmd_i | input | 16 | Command word: opcode in 15:12, target square in 9:4 |
| board_i | input | 256 | 64 square codes, 4 bits each, square n at bits 4n+3:4n |
| enable_i | input | 64 | Per-square enable mask |
| result_o | output | 8 | {illegal, end, square[5:0]} |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The bench uses the default board side of 8, so each ray lane runs its full 7 steps. Sliders reach from one edge of the board to the other, and index differences of 1, 7, 9, 10 and so on appear at the file boundaries, where wrap-around bugs would show. A reference model written as a forward walk from each candidate piece, with no ray lanes and no priority tree, checks directed positions for blocking, wrap, pawn direction, ties, masking and the illegal flag. It then checks pseudo-random positions.

// File: rtl/atk_pkg.sv
package atk_pkg;

  localparam int PIECE_W = 4;
  localparam int PRIO_W  = 3;

  localparam logic [3:0] OPC_FIND_ATK = 4'b1111;
  localparam logic [3:0] OPC_FIND_VIC = 4'b1110;

  typedef enum logic [2:0] {
    PT_NONE   = 3'd0,
    PT_PAWN   = 3'd1,
    PT_KNIGHT = 3'd2,
    PT_BISHOP = 3'd3,
    PT_ROOK   = 3'd4,
    PT_QUEEN  = 3'd5,
    PT_KING   = 3'd6,
    PT_RSVD   = 3'd7
  } ptype_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_PICK  = 2'd2
  } state_e;

  function automatic ptype_e kind_of(input logic [PIECE_W-1:0] p);
    return ptype_e'(p[2:0]);
  endfunction

  function automatic logic is_piece(input logic [PIECE_W-1:0] p);
    return (kind_of(p) != PT_NONE) && (kind_of(p) != PT_RSVD);
  endfunction

  function automatic logic is_friend(input logic [PIECE_W-1:0] p);
    return is_piece(p) && !p[3];
  endfunction

  function automatic logic is_foe(input logic [PIECE_W-1:0] p);
    return is_piece(p) && p[3];
  endfunction

  // Rank/file step of ray lane d: four orthogonal, then four diagonal.
  function automatic int dir_dr(input int d);
    case (d)
      2, 4, 5: return 1;
      3, 6, 7: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int dir_df(input int d);
    case (d)
      0, 4, 6: return 1;
      1, 5, 7: return -1;
      default: return 0;
    endcase
  endfunction

  // Cheaper attackers get the higher priority: pawn 6 down to king 1.
  function automatic logic [PRIO_W-1:0] atk_prio(input logic [PIECE_W-1:0] p);
    if (!is_friend(p)) return '0;
    case (kind_of(p))
      PT_PAWN:   return 3'd6;
      PT_KNIGHT: return 3'd5;
      PT_BISHOP: return 3'd4;
      PT_ROOK:   return 3'd3;
      PT_QUEEN:  return 3'd2;
      default:   return 3'd1;
    endcase
  endfunction

  // Dearer victims get the higher priority: the kind code itself.
  function automatic logic [PRIO_W-1:0] vic_prio(input logic [PIECE_W-1:0] p);
    return is_foe(p) ? p[2:0] : '0;
  endfunction

  // dr/df: target rank/file minus source rank/file.
  function automatic logic leaper_reach(input logic [PIECE_W-1:0] p,
                                        input int dr, input int df);
    int ar;
    int af;
    ar = (dr < 0) ? -dr : dr;
    af = (df < 0) ? -df : df;
    if (!is_friend(p)) return 1'b0;
    case (kind_of(p))
      PT_KNIGHT: return ((ar == 1) && (af == 2)) || ((ar == 2) && (af == 1));
      PT_KING:   return (ar <= 1) && (af <= 1) && ((ar + af) != 0);
      PT_PAWN:   return (dr == 1) && (af == 1);
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic slider_fits(input logic [PIECE_W-1:0] p, input logic diag);
    if (!is_friend(p)) return 1'b0;
    if (kind_of(p) == PT_QUEEN) return 1'b1;
    return diag ? (kind_of(p) == PT_BISHOP) : (kind_of(p) == PT_ROOK);
  endfunction

endpackage

// File: rtl/atk_ray_lane.sv
module atk_ray_lane
  import atk_pkg::*;
#(
  parameter int SIDE = 8,
  parameter int DR   = 0,
  parameter int DF   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   advance_i,
  input  logic [SIDE*SIDE-1:0]   seed_i,
  input  logic [SIDE*SIDE-1:0]   occ_i,
  input  logic [SIDE*SIDE-1:0]   kind_i,
  output logic [SIDE*SIDE-1:0]   hit_o
);

  localparam int NSQ = SIDE * SIDE;

  logic [NSQ-1:0] front_q;
  logic [NSQ-1:0] acc_q;
  logic [NSQ-1:0] stop_here;

  // Move every set bit one square in this lane's direction, dropping bits
  // that would leave the board.
  function automatic logic [NSQ-1:0] step_vec(input logic [NSQ-1:0] v);
    logic [NSQ-1:0] o;
    o = '0;
    for (int r = 0; r < SIDE; r++) begin
      for (int f = 0; f < SIDE; f++) begin
        if ((r + DR >= 0) && (r + DR < SIDE) && (f + DF >= 0) && (f + DF < SIDE))
          o[(r + DR) * SIDE + f + DF] = v[r * SIDE + f];
      end
    end
    return o;
  endfunction

  assign stop_here = front_q & occ_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front_q <= '0;
      acc_q   <= '0;
    end else if (load_i) begin
      front_q <= step_vec(seed_i);
      acc_q   <= '0;
    end else if (advance_i) begin
      acc_q   <= acc_q | (stop_here & kind_i);
      front_q <= step_vec(front_q & ~occ_i);
    end
  end

  assign hit_o = acc_q;

  // R3: a lane carries a single front that never splits.
  p_front_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(front_q));

  // R3: once a ray has left the board or been blocked it stays dead.
  p_ray_stays_dead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i && (front_q == '0)) |=> (front_q == '0));

  // R3: a recorded hit is a single blocker, never a square behind it.
  p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_q));

endmodule

// File: rtl/atk_leaper_map.sv
module atk_leaper_map
  import atk_pkg::*;
#(
  parameter int SIDE = 8
) (
  input  logic [$clog2(SIDE*SIDE)-1:0]   tgt_i,
  input  logic [SIDE*SIDE*PIECE_W-1:0]   board_i,
  output logic [SIDE*SIDE-1:0]           reach_o
);

  localparam int NSQ = SIDE * SIDE;

  int t_rank;
  int t_file;

  assign t_rank = int'(tgt_i) / SIDE;
  assign t_file = int'(tgt_i) % SIDE;

  for (genvar s = 0; s < NSQ; s++) begin : g_sq
    localparam int S_RANK = s / SIDE;
    localparam int S_FILE = s % SIDE;
    assign reach_o[s] = leaper_reach(board_i[s*PIECE_W +: PIECE_W],
                                     t_rank - S_RANK, t_file - S_FILE);
  end

endmodule

// File: rtl/atk_receiver_bank.sv
module atk_receiver_bank
  import atk_pkg::*;
#(
  parameter int NSQ = 64
) (
  input  logic                    find_atk_i,
  input  logic [NSQ*PIECE_W-1:0]  board_i,
  input  logic [NSQ-1:0]          enable_i,
  input  logic [NSQ-1:0]          attacked_i,
  output logic [NSQ*PRIO_W-1:0]   prio_o
);

  for (genvar s = 0; s < NSQ; s++) begin : g_rx
    logic [PIECE_W-1:0] pc;
    logic [PRIO_W-1:0]  lvl;
    assign pc = board_i[s*PIECE_W +: PIECE_W];
    always_comb begin
      if (!enable_i[s])    lvl = '0;
      else if (find_atk_i) lvl = attacked_i[s] ? atk_prio(pc) : '0;
      else                 lvl = vic_prio(pc);
    end
    assign prio_o[s*PRIO_W +: PRIO_W] = lvl;
  end

endmodule

// File: rtl/atk_prio_arbiter.sv
module atk_prio_arbiter #(
  parameter int N  = 64,
  parameter int PW = 3
) (
  input  logic [N*PW-1:0]        prio_i,
  output logic [$clog2(N)-1:0]   win_idx_o,
  output logic [PW-1:0]          win_prio_o
);

  localparam int IW = $clog2(N);

  // Level 0 holds the leaves in index order, so the left child always covers
  // lower squares and a tie keeps the left one.
  for (genvar l = 0; l <= IW; l++) begin : lvl
    localparam int CNT = N >> l;
    logic [PW-1:0] p  [CNT];
    logic [IW-1:0] ix [CNT];
    if (l == 0) begin : g_leaf
      for (genvar g = 0; g < CNT; g++) begin : g_n
        assign p[g]  = prio_i[g*PW +: PW];
        assign ix[g] = IW'(g);
      end
    end else begin : g_node
      for (genvar g = 0; g < CNT; g++) begin : g_n
        logic take_hi;
        assign take_hi = lvl[l-1].p[2*g+1] > lvl[l-1].p[2*g];
        assign p[g]    = take_hi ? lvl[l-1].p[2*g+1]  : lvl[l-1].p[2*g];
        assign ix[g]   = take_hi ? lvl[l-1].ix[2*g+1] : lvl[l-1].ix[2*g];
      end
    end
  end

  assign win_prio_o = lvl[IW].p[0];
  assign win_idx_o  = lvl[IW].ix[0];

endmodule

// File: rtl/atk_query_engine.sv
module atk_query_engine
  import atk_pkg::*;
#(
  parameter int SIDE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid_i,
  input  logic [15:0]                   cmd_i,
  input  logic [SIDE*SIDE*PIECE_W-1:0]  board_i,
  input  logic [SIDE*SIDE-1:0]          enable_i,
  output logic [7:0]                    result_o,
  output logic                          done_o
);

  localparam int NSQ       = SIDE * SIDE;
  localparam int IW        = $clog2(NSQ);
  localparam int RAY_STEPS = SIDE - 1;
  localparam int CNT_W     = (SIDE > 2) ? $clog2(SIDE) : 1;
  localparam int NDIR      = 8;

  state_e           st_q;
  logic [CNT_W-1:0] step_q;
  logic [IW-1:0]    tgt_q;
  logic             find_atk_q;
  logic [7:0]       result_q;
  logic             done_q;

  // Named events for the sequencer and its checks.
  logic [3:0]     cmd_op;
  logic [IW-1:0]  cmd_tgt;
  logic           start_atk;
  logic           start_vic;
  logic           sweeping;
  logic           last_step;

  assign cmd_op    = cmd_i[15:12];
  assign cmd_tgt   = cmd_i[4 +: IW];
  assign start_atk = (st_q == ST_IDLE) && cmd_valid_i && (cmd_op == OPC_FIND_ATK);
  assign start_vic = (st_q == ST_IDLE) && cmd_valid_i && (cmd_op == OPC_FIND_VIC);
  assign sweeping  = (st_q == ST_SWEEP);
  assign last_step = sweeping && (step_q == CNT_W'(RAY_STEPS - 1));

  // Per-square board views shared by the lanes.
  logic [NSQ-1:0] occ;
  logic [NSQ-1:0] orth_kind;
  logic [NSQ-1:0] diag_kind;
  logic [NSQ-1:0] seed_oh;

  for (genvar s = 0; s < NSQ; s++) begin : g_view
    logic [PIECE_W-1:0] pc;
    assign pc           = board_i[s*PIECE_W +: PIECE_W];
    assign occ[s]       = is_piece(pc);
    assign orth_kind[s] = slider_fits(pc, 1'b0);
    assign diag_kind[s] = slider_fits(pc, 1'b1);
  end

  assign seed_oh = NSQ'(1) << cmd_tgt;

  // Ray lanes, one per direction.
  logic [NSQ-1:0] lane_hit [NDIR];
  logic [NSQ-1:0] slider_hit;

  for (genvar d = 0; d < NDIR; d++) begin : g_lane
    localparam int DR = dir_dr(d);
    localparam int DF = dir_df(d);
    atk_ray_lane #(.SIDE(SIDE), .DR(DR), .DF(DF)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start_atk),
      .advance_i (sweeping),
      .seed_i    (seed_oh),
      .occ_i     (occ),
      .kind_i    (((DR != 0) && (DF != 0)) ? diag_kind : orth_kind),
      .hit_o     (lane_hit[d])
    );
  end

  always_comb begin
    slider_hit = '0;
    for (int d = 0; d < NDIR; d++) slider_hit = slider_hit | lane_hit[d];
  end

  // Knight, king and pawn attacks against the latched target.
  logic [NSQ-1:0] leap_hit;

  atk_leaper_map #(.SIDE(SIDE)) u_leap (
    .tgt_i   (tgt_q),
    .board_i (board_i),
    .reach_o (leap_hit)
  );

  logic [NSQ-1:0] attacked;
  assign attacked = slider_hit | leap_hit;

  // Receivers and arbitration.
  logic [NSQ*PRIO_W-1:0] prio_flat;
  logic [IW-1:0]         win_idx;
  logic [PRIO_W-1:0]     win_prio;

  atk_receiver_bank #(.NSQ(NSQ)) u_rx (
    .find_atk_i (find_atk_q),
    .board_i    (board_i),
    .enable_i   (enable_i),
    .attacked_i (attacked),
    .prio_o     (prio_flat)
  );

  atk_prio_arbiter #(.N(NSQ), .PW(PRIO_W)) u_arb (
    .prio_i     (prio_flat),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio)
  );

  logic [PIECE_W-1:0] tgt_piece;
  logic               king_in_check;
  logic               no_winner;
  logic [7:0]         next_result;

  assign tgt_piece     = board_i[int'(tgt_q)*PIECE_W +: PIECE_W];
  assign king_in_check = find_atk_q && is_foe(tgt_piece) &&
                         (kind_of(tgt_piece) == PT_KING) && (|attacked);
  assign no_winner     = (win_prio == '0);
  assign next_result   = {king_in_check, no_winner,
                          no_winner ? 6'd0 : 6'(win_idx)};

  // Sequencer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      step_q     <= '0;
      tgt_q      <= '0;
      find_atk_q <= 1'b0;
      result_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_atk) begin
            st_q       <= ST_SWEEP;
            step_q     <= '0;
            tgt_q      <= cmd_tgt;
            find_atk_q <= 1'b1;
          end else if (start_vic) begin
            st_q       <= ST_PICK;
            find_atk_q <= 1'b0;
          end
        end
        ST_SWEEP: begin
          step_q <= step_q + 1'b1;
          if (last_step) st_q <= ST_PICK;
        end
        ST_PICK: begin
          result_q <= next_result;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R7: a reported square is always enabled.
  p_winner_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !result_o[6]) |-> enable_i[result_o[IW-1:0]]);

  // R9: the end flag comes with a zero square field.
  p_end_square_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o[6]) |-> (result_o[5:0] == 6'd0));

  // R10: a victim query never raises the illegal flag.
  p_vic_not_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !find_atk_q) |-> !result_o[7]);

  // R11: done is a single-cycle pulse.
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: the sweep phase lasts exactly RAY_STEPS cycles.
  p_sweep_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && $past(start_atk)) |-> (step_q == '0));

  // R12: the latched query does not move while a query is in progress.
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> ($stable(tgt_q) && $stable(find_atk_q)));

  // R12: the result only changes together with done.
  p_result_only_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o) or $past(!rst_n));

endmodule

// File: tb/tb_atk_query_engine.sv
module tb_atk_query_engine;

  localparam int S   = 8;
  localparam int NSQ = S * S;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [15:0]       cmd_i = '0;
  logic [NSQ*4-1:0]  board_i = '0;
  logic [NSQ-1:0]    enable_i = '1;
  logic [7:0]        result_o;
  logic              done_o;

  atk_query_engine #(.SIDE(S)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .board_i     (board_i),
    .enable_i    (enable_i),
    .result_o    (result_o),
    .done_o      (done_o)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int pend  = 0;
  int dones = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] res;
    int         lat;
    int         issue;
    string      req;
  } exp_t;

  exp_t sbq[$];

  logic [3:0] bb [NSQ];
  logic       en [NSQ];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per done pulse.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      dones++;
      if (sbq.size() == 0) begin
        check(1'b0, "R12 unexpected done", result_o, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(result_o == e.res, e.req, result_o, e.res);
        check((cyc - e.issue) == e.lat, "R11 latency", cyc - e.issue, e.lat);
        pend--;
      end
    end
  end

  function automatic bit occupied(input logic [3:0] p);
    return (p[2:0] != 3'd0) && (p[2:0] != 3'd7);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int isgn(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  // Forward walk from the candidate piece toward the target.
  function automatic bit attacks(input int s, input int t);
    int sr, sf, dr, df, ar, af, ty, n;
    bit diag, orth;
    logic [3:0] p;
    p  = bb[s];
    ty = int'(p[2:0]);
    sr = s / S; sf = s % S;
    dr = t / S - sr; df = t % S - sf;
    ar = iabs(dr); af = iabs(df);
    if (s == t || p[3] || !occupied(p)) return 0;
    case (ty)
      1: return (dr == 1) && (af == 1);
      2: return (ar * af) == 2;
      6: return (ar <= 1) && (af <= 1);
      default: begin
        diag = (ar == af);
        orth = (ar == 0) || (af == 0);
        if (!((diag && ty != 4) || (orth && ty != 3))) return 0;
        n = (ar > af) ? ar : af;
        for (int k = 1; k < n; k++)
          if (occupied(bb[(sr + k * isgn(dr)) * S + sf + k * isgn(df)])) return 0;
        return 1;
      end
    endcase
  endfunction

  function automatic logic [7:0] model_atk(input int t);
    int best, bty;
    bit any;
    best = -1; bty = 9; any = 0;
    for (int i = 0; i < NSQ; i++) begin
      if (attacks(i, t)) begin
        any = 1;
        if (en[i] && int'(bb[i][2:0]) < bty) begin
          bty = int'(bb[i][2:0]); best = i;
        end
      end
    end
    return {(bb[t] == 4'b1110) && any, best < 0, (best < 0) ? 6'd0 : 6'(best)};
  endfunction

  function automatic logic [7:0] model_vic();
    int best, bty;
    best = -1; bty = 0;
    for (int i = 0; i < NSQ; i++)
      if (en[i] && bb[i][3] && occupied(bb[i]) && int'(bb[i][2:0]) > bty) begin
        bty = int'(bb[i][2:0]); best = i;
      end
    return {1'b0, best < 0, (best < 0) ? 6'd0 : 6'(best)};
  endfunction

  task automatic clear_board();
    for (int i = 0; i < NSQ; i++) begin bb[i] = 4'd0; en[i] = 1'b1; end
  endtask

  task automatic push_board();
    for (int i = 0; i < NSQ; i++) begin
      board_i[i*4 +: 4] = bb[i];
      enable_i[i]       = en[i];
    end
  endtask

  // Driver: pushes the expectation, presents the command, waits for the result.
  task automatic query(input bit atk, input int t, input string req, input bit poke);
    exp_t e;
    @(negedge clk);
    push_board();
    e.res   = atk ? model_atk(t) : model_vic();
    e.lat   = atk ? S : 1;
    e.issue = cyc + 1;
    e.req   = req;
    sbq.push_back(e);
    pend++;
    cmd_valid_i = 1'b1;
    cmd_i = {atk ? 4'b1111 : 4'b1110, 2'b00, 6'(t), 4'b0000};
    @(negedge clk);
    cmd_valid_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      cmd_valid_i = 1'b1;
      cmd_i = {4'b1110, 12'd0};
      @(negedge clk);
      cmd_valid_i = 1'b0;
    end
    wait (pend == 0);
    @(negedge clk);
  endtask

  int unsigned rs = 32'h1234_5678;
  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    int d0;
    clear_board();
    push_board();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(result_o == 8'h00, "R1 reset result", result_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);

    // R9: empty board.
    query(0, 0, "R9 empty victim", 0);
    query(1, 27, "R9 empty attacker", 0);

    // R3: rook along a full file, then blocked by either colour.
    clear_board(); bb[0] = 4'b0100;
    query(1, 56, "R3 rook reach", 0);
    bb[24] = 4'b1001;
    query(1, 56, "R3 blocked by enemy", 0);
    bb[24] = 4'b0011;
    query(1, 56, "R3 blocked by friend", 0);
    clear_board(); bb[7] = 4'b0011;
    query(1, 56, "R3 bishop diagonal", 0);

    // R2: cheapest friendly attacker, enemies ignored.
    clear_board(); bb[1] = 4'b0010; bb[2] = 4'b0101; bb[33] = 4'b1010;
    query(1, 18, "R2 knight over queen", 0);
    bb[1] = 4'b1010;
    query(1, 18, "R2 enemy not attacker", 0);

    // R4: leaper geometry and edge wrap.
    clear_board(); bb[7] = 4'b0010;
    query(1, 17, "R4 knight wrap", 0);
    bb[31] = 4'b0110;
    query(1, 32, "R4 king wrap", 0);
    clear_board(); bb[28] = 4'b0110;
    query(1, 37, "R4 king adjacent", 0);

    // R5: pawn direction and wrap.
    clear_board(); bb[27] = 4'b0001; bb[8] = 4'b0001;
    query(1, 36, "R5 pawn right", 0);
    query(1, 34, "R5 pawn left", 0);
    query(1, 18, "R5 pawn backward", 0);
    query(1, 15, "R5 pawn wrap", 0);

    // R7: disabled attacker skipped.
    clear_board(); bb[0] = 4'b0100; bb[49] = 4'b0001;
    query(1, 56, "R7 pawn enabled", 0);
    en[49] = 1'b0;
    query(1, 56, "R7 pawn disabled", 0);

    // R8: equal attackers, lowest index.
    clear_board(); bb[28] = 4'b0010; bb[17] = 4'b0010; bb[1] = 4'b0010;
    query(1, 11, "R8 knight tie", 0);

    // R6 and R8 on the victim side.
    clear_board(); bb[40] = 4'b1101; bb[10] = 4'b1100; bb[4] = 4'b0110; bb[50] = 4'b1100;
    query(0, 0, "R6 queen victim", 0);
    en[40] = 1'b0;
    query(0, 0, "R8 rook tie victim", 0);

    // R10: enemy king under attack, enabled or not.
    clear_board(); bb[60] = 4'b1110; bb[4] = 4'b0100;
    query(1, 60, "R10 king attacked", 0);
    en[4] = 1'b0;
    query(1, 60, "R10 attacker disabled", 0);
    en[4] = 1'b1; bb[36] = 4'b1001;
    query(1, 60, "R10 king shielded", 0);
    query(0, 0, "R10 victim no flag", 0);

    // R12: other opcodes ignored.
    held = result_o; d0 = dones;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_i = 16'hD011;
    @(negedge clk); cmd_i = 16'hA000;
    @(negedge clk); cmd_i = 16'h0000;
    @(negedge clk); cmd_valid_i = 1'b0;
    repeat (12) @(negedge clk);
    check(result_o == held, "R12 result held", result_o, held);
    check(dones == d0, "R12 no done", dones - d0, 0);

    // R12: command during a running query ignored.
    clear_board(); bb[0] = 4'b0100; bb[63] = 4'b1101;
    d0 = dones;
    query(1, 56, "R12 busy query", 1);
    repeat (10) @(negedge clk);
    check(dones == d0 + 1, "R12 single done", dones - d0, 1);

    // Pseudo-random positions.
    for (int b = 0; b < 20; b++) begin
      for (int i = 0; i < NSQ; i++) begin
        bb[i] = ((rnd() % 8) < 5) ? 4'd0 : {rnd() % 2 == 1, 3'(1 + rnd() % 6)};
        en[i] = (rnd() % 4) != 0;
      end
      for (int q = 0; q < 4; q++) query(1, int'(rnd() % NSQ), "R2 random attacker", 0);
      query(0, 0, "R6 random victim", 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule